// File: doc/BRIEF.md
# Privileged Tick Timer Register

This block holds a free-running processor tick counter and a companion compare register. Both are 64 bits wide. The lower 63 bits of each register carry a value. The top bit of each register is a control flag that belongs to that register alone. On the counter, the top bit is a user-read trap flag: while it is set, a counter read by a requester below supervisor level is refused with a privilege exception instead of returning data. On the compare register, the top bit is an interrupt mask: while it is set, the block raises no match interrupt. A write to either register changes only that register's flag, so the two flags are never mixed up.

The counter advances once for every cycle in which the tick enable input is high. Software loads either register through a single write port and reads either one through a read port that carries the requester's privilege level. When the count reaches the compare value and the mask is clear, a one-cycle interrupt pulse is produced. One instance is placed per time source, for example core tick, system tick or hypervisor tick.

Top module: `tick_timer`

## Requirements
- R1: After reset the count and the compare value are 0, the trap flag and the interrupt mask are both 1, and rd_valid_o, priv_exc_o, irq_o and rd_data_o are 0.
- R2: The count (bits 62:0) increases by exactly one at each clock edge where tick_en_i is 1 and no counter write is applied. It holds its value otherwise.
- R3: When the count is all ones in bits 62:0, a tick takes it to 0. The trap flag does not change.
- R4: A write with wr_sel_i = 0 (counter) loads bits 62:0 into the count and bit 63 into the trap flag, and leaves the interrupt mask unchanged. In the same cycle it takes priority over tick_en_i.
- R5: A write with wr_sel_i = 1 (compare) loads bits 62:0 into the compare value and bit 63 into the interrupt mask, and leaves the count and the trap flag unchanged.
- R6: A successful counter read (rd_sel_i = 0) presents {trap flag, count} on rd_data_o, with rd_valid_o = 1, in the cycle after rd_en_i. The value is the one held before any write or tick in the request cycle.
- R7: A counter read with the trap flag at 1 and rd_priv_i below 1 (supervisor) gives priv_exc_o = 1, rd_valid_o = 0 and rd_data_o = 0 in the next cycle. Count and flags are not altered.
- R8: A read with rd_priv_i of 1 or more always completes with rd_valid_o = 1, whatever the trap flag holds.
- R9: irq_o pulses high for exactly one cycle, one cycle after the condition (count equals compare value in bits 62:0, with the mask at 0) becomes true. No pulse is produced while the mask is 1.
- R10: A compare read (rd_sel_i = 1) presents {interrupt mask, compare value} in the next cycle at any privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Advance the count by one this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 compare |
| wr_data_i | input | 64 | Write data; bit 63 is the flag of the target register |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 1 | Read target: 0 counter, 1 compare |
| rd_priv_i | input | 2 | Requester privilege: 0 user, 1 supervisor, 2 or more higher |
| rd_data_o | output | 64 | Read data, registered |
| rd_valid_o | output | 1 | Read completed, registered |
| priv_exc_o | output | 1 | Read refused for privilege, registered |
| irq_o | output | 1 | Compare match interrupt pulse |

## Verification
Every result is due at a fixed offset. Read data, rd_valid_o and priv_exc_o appear on the edge that samples the request. A write or a tick becomes visible to a read issued in the following cycle. irq_o rises one edge after the match condition starts to hold. The bench drives each cycle's inputs after a falling edge and updates a reference model with exactly these offsets. It compares all four outputs at the next falling edge, so each check falls midway between the edges that could change the value.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    REG_CNT = 1'b0,
    REG_CMP = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             ld_i,
  input  logic [VAL_W-1:0] ld_val_i,
  input  logic             ld_flag_i,
  output logic [VAL_W-1:0] val_o,
  output logic             npt_o
);
  logic [VAL_W-1:0] val_q;
  logic             npt_q;

  // load beats tick; wrap is natural modulo 2^VAL_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      npt_q <= 1'b1;
    end else if (ld_i) begin
      val_q <= ld_val_i;
      npt_q <= ld_flag_i;
    end else if (tick_en_i) begin
      val_q <= val_q + 1'b1;
    end
  end

  assign val_o = val_q;
  assign npt_o = npt_q;
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [VAL_W-1:0] ld_val_i,
  input  logic             ld_flag_i,
  input  logic [VAL_W-1:0] cnt_i,
  output logic [VAL_W-1:0] cmp_o,
  output logic             int_dis_o,
  output logic             irq_o
);
  logic [VAL_W-1:0] cmp_q;
  logic             int_dis_q;
  logic             hit, hit_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q     <= '0;
      int_dis_q <= 1'b1;
    end else if (ld_i) begin
      cmp_q     <= ld_val_i;
      int_dis_q <= ld_flag_i;
    end
  end

  assign hit = (cnt_i == cmp_q) && !int_dis_q;

  // pulse on the rising edge of the match condition only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hit_q <= hit;
      irq_q <= hit && !hit_q;
    end
  end

  assign cmp_o     = cmp_q;
  assign int_dis_o = int_dis_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/tick_rd_port.sv
module tick_rd_port #(
  parameter int W       = 64,
  parameter int PRIV_W  = 2,
  parameter int SUP_LVL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  input  logic [PRIV_W-1:0] rd_priv_i,
  input  logic [W-1:0]      cnt_word_i,
  input  logic [W-1:0]      cmp_word_i,
  output logic [W-1:0]      rd_data_o,
  output logic              rd_valid_o,
  output logic              priv_exc_o
);
  import tick_pkg::*;

  localparam logic [PRIV_W-1:0] SUP = PRIV_W'(SUP_LVL);

  logic         is_cnt, trap, ok;
  logic [W-1:0] sel_word;

  assign is_cnt   = (rd_sel_i == REG_CNT);
  // the trap flag sits in the top bit of the counter word
  assign trap     = rd_en_i && is_cnt && cnt_word_i[W-1] && (rd_priv_i < SUP);
  assign ok       = rd_en_i && !trap;
  assign sel_word = is_cnt ? cnt_word_i : cmp_word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      priv_exc_o <= 1'b0;
    end else begin
      rd_data_o  <= ok ? sel_word : '0;
      rd_valid_o <= ok;
      priv_exc_o <= trap;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int W       = 64,
  parameter int PRIV_W  = 2,
  parameter int SUP_LVL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  input  logic [PRIV_W-1:0] rd_priv_i,
  output logic [W-1:0]      rd_data_o,
  output logic              rd_valid_o,
  output logic              priv_exc_o,
  output logic              irq_o
);
  import tick_pkg::*;

  localparam int VAL_W = W - 1;

  logic [VAL_W-1:0] cnt_val, cmp_val;
  logic             npt, int_dis;
  logic             wr_cnt, wr_cmp;

  assign wr_cnt = wr_en_i && (wr_sel_i == REG_CNT);
  assign wr_cmp = wr_en_i && (wr_sel_i == REG_CMP);

  tick_counter #(.VAL_W(VAL_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .ld_i      (wr_cnt),
    .ld_val_i  (wr_data_i[VAL_W-1:0]),
    .ld_flag_i (wr_data_i[W-1]),
    .val_o     (cnt_val),
    .npt_o     (npt)
  );

  tick_compare #(.VAL_W(VAL_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (wr_cmp),
    .ld_val_i  (wr_data_i[VAL_W-1:0]),
    .ld_flag_i (wr_data_i[W-1]),
    .cnt_i     (cnt_val),
    .cmp_o     (cmp_val),
    .int_dis_o (int_dis),
    .irq_o     (irq_o)
  );

  tick_rd_port #(.W(W), .PRIV_W(PRIV_W), .SUP_LVL(SUP_LVL)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .rd_priv_i  (rd_priv_i),
    .cnt_word_i ({npt, cnt_val}),
    .cmp_word_i ({int_dis, cmp_val}),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .priv_exc_o (priv_exc_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int W       = 64,
  parameter int PRIV_W  = 2,
  parameter int SUP_LVL = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_en_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [W-1:0]      wr_data_i,
  input logic              rd_en_i,
  input logic              rd_sel_i,
  input logic [PRIV_W-1:0] rd_priv_i,
  input logic              rd_valid_o,
  input logic              priv_exc_o,
  input logic              irq_o,
  input logic [W-2:0]      cnt_val,
  input logic              npt,
  input logic              int_dis
);
  localparam logic [PRIV_W-1:0] SUP = PRIV_W'(SUP_LVL);

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en_i && !(wr_en_i && !wr_sel_i)) |=> cnt_val == $past(cnt_val) + 1'b1);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !(wr_en_i && !wr_sel_i)) |=> $stable(cnt_val) && $stable(npt));

  assert_cnt_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> npt == $past(wr_data_i[W-1]) && $stable(int_dis));

  assert_cmp_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> int_dis == $past(wr_data_i[W-1]) && $stable(npt));

  assert_exc_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_exc_o |-> !rd_valid_o);

  assert_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i && npt && rd_priv_i < SUP) |=> priv_exc_o);

  assert_sup_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_priv_i >= SUP) |=> rd_valid_o && !priv_exc_o);

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_dis && $stable(int_dis)) |=> !irq_o);
endmodule

bind tick_timer tick_timer_chk #(.W(W), .PRIV_W(PRIV_W), .SUP_LVL(SUP_LVL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_en_i  (tick_en_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_sel_i   (rd_sel_i),
  .rd_priv_i  (rd_priv_i),
  .rd_valid_o (rd_valid_o),
  .priv_exc_o (priv_exc_o),
  .irq_o      (irq_o),
  .cnt_val    (cnt_val),
  .npt        (npt),
  .int_dis    (int_dis)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0, rd_sel_i = 1'b0;
  logic [1:0]  rd_priv_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_valid_o, priv_exc_o, irq_o;

  int checks = 0, errors = 0;

  // reference model
  logic [62:0] m_cnt = '0, m_cmp = '0;
  logic        m_npt = 1'b1, m_int = 1'b1, m_hit_prev = 1'b0;
  logic [63:0] e_data = '0;
  logic        e_valid = 1'b0, e_exc = 1'b0, e_irq = 1'b0;

  localparam logic [62:0] ONES = {63{1'b1}};

  always #4 clk_i = ~clk_i;

  tick_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_priv_i(rd_priv_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .priv_exc_o(priv_exc_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_ok(input bit rs, input logic [1:0] pr);
    return rs || !m_npt || (pr >= 2'd1);
  endfunction

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input bit te, input bit we, input bit ws, input logic [63:0] wd,
                     input bit re, input bit rs, input logic [1:0] pr, input string tag);
    bit hit;
    tick_en_i = te; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
    rd_en_i = re; rd_sel_i = rs; rd_priv_i = pr;
    e_valid = re && is_ok(rs, pr);
    e_exc   = re && !rs && m_npt && (pr < 2'd1);
    e_data  = e_valid ? (rs ? {m_int, m_cmp} : {m_npt, m_cnt}) : 64'd0;
    hit = (m_cnt == m_cmp) && !m_int;
    e_irq = hit && !m_hit_prev;
    m_hit_prev = hit;
    if (we && !ws) begin
      m_cnt = wd[62:0]; m_npt = wd[63];
    end else if (te) begin
      m_cnt = m_cnt + 1'b1;
    end
    if (we && ws) begin
      m_cmp = wd[62:0]; m_int = wd[63];
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(rd_valid_o === e_valid, {tag, " R8 rd_valid"}, 64'(rd_valid_o), 64'(e_valid));
    chk(priv_exc_o === e_exc, {tag, " R7 priv_exc"}, 64'(priv_exc_o), 64'(e_exc));
    chk(rd_data_o === e_data, {tag, rs ? " R10 cmp data" : " R6 cnt data"}, rd_data_o, e_data);
    chk(irq_o === e_irq, {tag, " R9 irq"}, 64'(irq_o), 64'(e_irq));
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 64'd0, 0, 0, 2'd0, tag);
  endtask

  task automatic rd(input bit rs, input logic [1:0] pr, input string tag);
    cyc(0, 0, 0, 64'd0, 1, rs, pr, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: outputs quiet, then flags read back as set
    chk({rd_valid_o, priv_exc_o, irq_o} === 3'b000, "R1 reset outputs", 64'({rd_valid_o, priv_exc_o, irq_o}), 64'd0);
    chk(rd_data_o === 64'd0, "R1 reset data", rd_data_o, 64'd0);
    rd(0, 2'd1, "R1");
    chk(rd_data_o === {1'b1, 63'd0}, "R1 trap flag set", rd_data_o, {1'b1, 63'd0});
    rd(1, 2'd0, "R1");
    chk(rd_data_o === {1'b1, 63'd0}, "R1 mask set", rd_data_o, {1'b1, 63'd0});

    // R7: user read trapped, state intact
    cyc(1, 0, 0, 64'd0, 1, 0, 2'd0, "R7");
    rd(0, 2'd2, "R7");
    // R4: write wins over tick, clears trap flag, mask untouched
    cyc(1, 1, 0, {1'b0, 63'd5}, 0, 0, 2'd0, "R4");
    rd(0, 2'd0, "R4");
    rd(1, 2'd3, "R4");
    // R2: three ticks then read
    cyc(1, 0, 0, 64'd0, 0, 0, 2'd0, "R2");
    cyc(1, 0, 0, 64'd0, 0, 0, 2'd0, "R2");
    cyc(1, 0, 0, 64'd0, 1, 0, 2'd0, "R2");
    rd(0, 2'd0, "R2");
    chk(m_cnt == 63'd8, "R2 model count", 64'(m_cnt), 64'd8);
    // R3: wrap keeps the trap flag
    cyc(0, 1, 0, {1'b1, ONES}, 0, 0, 2'd0, "R3");
    cyc(1, 0, 0, 64'd0, 1, 0, 2'd1, "R3");
    rd(0, 2'd1, "R3");
    chk(rd_data_o === {1'b1, 63'd0}, "R3 wrapped", rd_data_o, {1'b1, 63'd0});
    // R5: compare write leaves trap flag
    cyc(0, 1, 1, {1'b0, 63'd10}, 0, 0, 2'd0, "R5");
    rd(0, 2'd0, "R5");
    rd(1, 2'd0, "R5");
    // R9: match with mask clear
    cyc(0, 1, 0, {1'b0, 63'd8}, 0, 0, 2'd0, "R9");
    cyc(1, 0, 0, 64'd0, 0, 0, 2'd0, "R9");
    cyc(1, 0, 0, 64'd0, 0, 0, 2'd0, "R9");
    idle("R9");
    chk(irq_o === 1'b1, "R9 pulse due", 64'(irq_o), 64'd1);
    idle("R9");
    idle("R9");
    // R9: masked match gives nothing
    cyc(0, 1, 1, {1'b1, 63'd12}, 0, 0, 2'd0, "R9m");
    cyc(0, 1, 0, {1'b0, 63'd11}, 0, 0, 2'd0, "R9m");
    cyc(1, 0, 0, 64'd0, 0, 0, 2'd0, "R9m");
    idle("R9m");
    idle("R9m");

    // random mix, small values so matches occur
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] wd;
      wd = {1'($urandom), 59'd0, 4'($urandom)};
      cyc(1'($urandom), ($urandom % 5) == 0, 1'($urandom), wd,
          ($urandom % 3) == 0, 1'($urandom), 2'($urandom), "RND");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule